// File: doc/BRIEF.md
# Receive Idle Timeout Timer

This block watches the receive side of a serial port for silence. Each time a received character is stored, it starts a countdown measured in whole character times. The caller supplies a one-cycle tick for each character time. If no further character arrives before the countdown ends, the block raises a sticky timeout status flag. In the same cycle it emits a one-cycle pulse that the surrounding logic uses to set its receive interrupt source.

Software programs the countdown through a 16-bit control word. Bit 7 turns the timer on, bits [15:12] give the timeout length in character times, and bit 11 lets the timeout fire even when no received data is waiting. The timer stops when the receive buffer reaches its trigger level, because the trigger request already informs software. The status flag stays set until software writes a one to bit 3 of the status word.

Top module: `rx_idle_timer`

## Requirements
- R1: After reset `timeoutFlag` and `rxIntSet` are 0 and the timer is idle, so word ticks alone produce no pulse.
- R2: The timer runs only while `ctrlWord[7]` is 1. A `rxStored` pulse seen while bit 7 is 0 is ignored. Clearing bit 7 for any cycle cancels a running countdown, and setting it again does not resume the countdown.
- R3: A `rxStored` pulse with bit 7 set loads the multiplier m from `ctrlWord[15:12]`. The countdown expires on the max(m,1)-th `wordTick` that follows, so m = 0 expires on the first tick.
- R4: A `rxStored` pulse while the countdown is running restarts it from the full multiplier.
- R5: A `rxTrigHit` pulse cancels the countdown. When `rxTrigHit` and `rxStored` arrive in the same cycle, the cancel wins.
- R6: On expiry the block acts only if `dataReady` is 1 or `ctrlWord[11]` is 1 in the expiring cycle. Otherwise it returns to idle with no pulse and no flag change.
- R7: When expiry acts, `rxIntSet` is 1 for exactly one cycle and `timeoutFlag` becomes 1 at the same clock edge. That edge is the one that samples the expiring tick.
- R8: Each arming produces at most one pulse. Further ticks after expiry produce nothing until the next `rxStored`.
- R9: `timeoutFlag` clears only on a cycle where `statusWrEn` is 1 and `statusWrData[3]` is 1. Other data bits, or data without the enable, have no effect. A set and a clear in the same cycle leave the flag set.
- R10: A change of `ctrlWord[15:12]` while the countdown is running does not alter that countdown.
- R11: If `rxStored` arrives in the same cycle as the expiring tick, the restart wins and no pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wordTick | input | 1 | One-cycle pulse per character time |
| ctrlWord | input | 16 | Control: [7] enable, [11] fire on empty, [15:12] multiplier |
| rxStored | input | 1 | Pulse: received data was stored |
| rxTrigHit | input | 1 | Pulse: receive buffer reached its trigger level |
| dataReady | input | 1 | Receive data is waiting to be read |
| statusWrEn | input | 1 | Status word write strobe |
| statusWrData | input | 4 | Status write data; bit 3 clears the timeout flag |
| timeoutFlag | output | 1 | Sticky receive timeout status |
| rxIntSet | output | 1 | One-cycle pulse to set the receive interrupt source |

## Verification
A countdown that is loaded wrongly, decremented on the wrong cycle, or left armed shows up at `rxIntSet`. The pulse arrives on a different tick than max(m,1), or appears again on later ticks, and this is visible within at most sixteen ticks of the arming. A broken arm or cancel path shows as a pulse that should never come, or as a pulse missing after cancel, restart or disable. A flag register with a wrong set or clear rule shows on `timeoutFlag` one edge after the offending write or expiry. The multiplier sweep covers every value under all four combinations of data-ready and empty-fire, so each error in the count appears as a tick-index mismatch.

// File: rtl/rx_idle_pkg.sv
package rx_idle_pkg;

  // strobes issued by the control path to the datapath
  typedef struct packed {
    logic load;   // load countdown from multiplier
    logic dec;    // decrement countdown
    logic fire;   // expiry acts: pulse and set flag
  } idleStrb_t;

  typedef enum logic {
    IDLE_S  = 1'b0,
    ARMED_S = 1'b1
  } idleState_e;

endpackage

// File: rtl/rx_idle_ctrl.sv
module rx_idle_ctrl
  import rx_idle_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      enable,
  input  logic      emptyOpt,
  input  logic      wordTick,
  input  logic      rxStored,
  input  logic      rxTrigHit,
  input  logic      dataReady,
  input  logic      cntLeOne,
  output idleStrb_t strb
);

  idleState_e state, stateNext;
  logic       cancel;

  assign cancel = !enable || rxTrigHit;

  always_comb begin
    stateNext = state;
    strb      = '0;
    if (cancel) begin
      stateNext = IDLE_S;
    end else if (rxStored) begin
      strb.load = 1'b1;
      stateNext = ARMED_S;
    end else if (state == ARMED_S && wordTick) begin
      if (cntLeOne) begin
        stateNext = IDLE_S;
        strb.fire = dataReady || emptyOpt;
      end else begin
        strb.dec = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= IDLE_S;
    else       state <= stateNext;
  end

  // R7
  fire_when_armed_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.fire |-> (state == ARMED_S) && wordTick);

  // R2
  disable_idles_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (state == IDLE_S));

  // R5
  trig_cancels_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxTrigHit |=> (state == IDLE_S));

  // R8
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb));

endmodule

// File: rtl/rx_idle_dp.sv
module rx_idle_dp
  import rx_idle_pkg::*;
#(
  parameter int MULT_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  idleStrb_t         strb,
  input  logic [MULT_W-1:0] multVal,
  input  logic              clrReq,
  output logic              cntLeOne,
  output logic              timeoutFlag,
  output logic              rxIntSet
);

  logic [MULT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (strb.load) begin
      cnt <= multVal;
    end else if (strb.dec) begin
      cnt <= cnt - MULT_W'(1);
    end
  end

  assign cntLeOne = (cnt <= MULT_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      timeoutFlag <= 1'b0;
      rxIntSet    <= 1'b0;
    end else begin
      rxIntSet <= strb.fire;
      if (strb.fire)   timeoutFlag <= 1'b1;
      else if (clrReq) timeoutFlag <= 1'b0;
    end
  end

  // R3
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.dec |-> (cnt > MULT_W'(1)));

  // R7
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxIntSet |=> !rxIntSet);

  // R7
  flag_with_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(timeoutFlag) |-> rxIntSet);

  // R9
  flag_clear_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(timeoutFlag) |-> $past(clrReq));

endmodule

// File: rtl/rx_idle_timer.sv
module rx_idle_timer
  import rx_idle_pkg::*;
#(
  parameter int CTRL_W   = 16,
  parameter int ENA_BIT  = 7,
  parameter int OPT_BIT  = 11,
  parameter int MULT_LSB = 12,
  parameter int MULT_W   = 4,
  parameter int STAT_W   = 4,
  parameter int FLAG_BIT = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wordTick,
  input  logic [CTRL_W-1:0] ctrlWord,
  input  logic              rxStored,
  input  logic              rxTrigHit,
  input  logic              dataReady,
  input  logic              statusWrEn,
  input  logic [STAT_W-1:0] statusWrData,
  output logic              timeoutFlag,
  output logic              rxIntSet
);

  localparam int MULT_MSB = MULT_LSB + MULT_W - 1;

  idleStrb_t         strb;
  logic              cntLeOne;
  logic              clrReq;
  logic [MULT_W-1:0] multVal;

  assign multVal = ctrlWord[MULT_MSB:MULT_LSB];
  assign clrReq  = statusWrEn && statusWrData[FLAG_BIT];

  rx_idle_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .enable    (ctrlWord[ENA_BIT]),
    .emptyOpt  (ctrlWord[OPT_BIT]),
    .wordTick  (wordTick),
    .rxStored  (rxStored),
    .rxTrigHit (rxTrigHit),
    .dataReady (dataReady),
    .cntLeOne  (cntLeOne),
    .strb      (strb)
  );

  rx_idle_dp #(.MULT_W(MULT_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .multVal     (multVal),
    .clrReq      (clrReq),
    .cntLeOne    (cntLeOne),
    .timeoutFlag (timeoutFlag),
    .rxIntSet    (rxIntSet)
  );

endmodule

// File: tb/rx_idle_timer_bench.sv
module rx_idle_timer_bench;

  logic        clk = 1'b0;
  logic        rstN;
  logic        wordTick, rxStored, rxTrigHit, dataReady, statusWrEn;
  logic [15:0] ctrlWord;
  logic [3:0]  statusWrData;
  logic        timeoutFlag, rxIntSet;

  int total = 0;
  int bad   = 0;
  int cycles = 0;
  bit doneFlag = 0;

  always #4 clk = ~clk;

  rx_idle_timer u_rx_idle_timer (
    .clk(clk), .rstN(rstN), .wordTick(wordTick), .ctrlWord(ctrlWord),
    .rxStored(rxStored), .rxTrigHit(rxTrigHit), .dataReady(dataReady),
    .statusWrEn(statusWrEn), .statusWrData(statusWrData),
    .timeoutFlag(timeoutFlag), .rxIntSet(rxIntSet)
  );

  function automatic logic [15:0] mkCtrl(int m, bit ena, bit opt);
    return (16'(m) << 12) | (16'(opt) << 11) | (16'(ena) << 7);
  endfunction

  task automatic chk(logic act, logic exp, string req);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic store();
    rxStored = 1'b1; cyc(); rxStored = 1'b0;
  endtask

  task automatic tick();
    wordTick = 1'b1; cyc(); wordTick = 1'b0;
  endtask

  task automatic clearFlag();
    statusWrEn = 1'b1; statusWrData = 4'b1000; cyc();
    statusWrEn = 1'b0; statusWrData = 4'b0000;
  endtask

  // n ticks; pulse expected only after tick number 'at' (0 = never)
  task automatic tickRun(int n, int at, string req);
    for (int k = 1; k <= n; k++) begin
      tick();
      chk(rxIntSet, (k == at), req);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !doneFlag) begin
      doneFlag = 1;
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; wordTick = 0; rxStored = 0; rxTrigHit = 0; dataReady = 0;
    statusWrEn = 0; statusWrData = 0; ctrlWord = mkCtrl(2, 1, 1);
    repeat (3) cyc();
    // R1 reset state
    chk(timeoutFlag, 1'b0, "R1");
    chk(rxIntSet, 1'b0, "R1");
    rstN = 1'b1;
    cyc();
    tickRun(4, 0, "R1");
    chk(timeoutFlag, 1'b0, "R1");

    // R3 R6 R7 R8 sweep over multiplier and ready/option
    for (int m = 0; m < 16; m++) begin
      for (int sel = 0; sel < 4; sel++) begin
        bit rdy = sel[0];
        bit opt = sel[1];
        bit fire = rdy | opt;
        int expAt = (m == 0) ? 1 : m;
        ctrlWord = mkCtrl(m, 1, opt);
        dataReady = rdy;
        store();
        chk(rxIntSet, 1'b0, "R3");
        for (int k = 1; k <= 17; k++) begin
          tick();
          chk(rxIntSet, fire && (k == expAt), "R3");
          cyc();
          chk(rxIntSet, 1'b0, "R7");
          if (k == expAt) chk(timeoutFlag, fire, "R6");
        end
        chk(timeoutFlag, fire, "R8");
        statusWrEn = 1'b1; statusWrData = 4'b0111; cyc();
        statusWrEn = 1'b0;
        chk(timeoutFlag, fire, "R9");
        statusWrData = 4'b1000; cyc();
        chk(timeoutFlag, fire, "R9");
        clearFlag();
        chk(timeoutFlag, 1'b0, "R9");
      end
    end
    dataReady = 1'b1;

    // R2 disabled: stored ignored
    ctrlWord = mkCtrl(2, 0, 1);
    store();
    ctrlWord = mkCtrl(2, 1, 1);
    tickRun(4, 0, "R2");
    chk(timeoutFlag, 1'b0, "R2");
    // R2 clearing bit 7 cancels running countdown
    store();
    tick();
    ctrlWord = mkCtrl(2, 0, 1); cyc();
    ctrlWord = mkCtrl(2, 1, 1);
    tickRun(4, 0, "R2");

    // R4 restart
    ctrlWord = mkCtrl(3, 1, 0);
    store();
    tickRun(2, 0, "R4");
    store();
    tickRun(4, 3, "R4");
    clearFlag();

    // R10 multiplier change mid-count
    store();
    ctrlWord = mkCtrl(1, 1, 0);
    tickRun(4, 3, "R10");
    clearFlag();

    // R5 trigger cancels
    ctrlWord = mkCtrl(2, 1, 0);
    store();
    tick();
    rxTrigHit = 1'b1; cyc(); rxTrigHit = 1'b0;
    tickRun(3, 0, "R5");
    rxTrigHit = 1'b1; rxStored = 1'b1; cyc();
    rxTrigHit = 1'b0; rxStored = 1'b0;
    tickRun(3, 0, "R5");
    chk(timeoutFlag, 1'b0, "R5");

    // R11 restart beats expiring tick
    store();
    tick();
    wordTick = 1'b1; rxStored = 1'b1; cyc();
    wordTick = 1'b0; rxStored = 1'b0;
    chk(rxIntSet, 1'b0, "R11");
    tickRun(2, 2, "R11");
    clearFlag();

    // R9 set wins over clear in the same cycle
    ctrlWord = mkCtrl(1, 1, 0);
    store();
    wordTick = 1'b1; statusWrEn = 1'b1; statusWrData = 4'b1000; cyc();
    wordTick = 1'b0; statusWrEn = 1'b0; statusWrData = 4'b0000;
    chk(rxIntSet, 1'b1, "R9");
    chk(timeoutFlag, 1'b1, "R9");
    clearFlag();
    chk(timeoutFlag, 1'b0, "R9");

    if (!doneFlag) begin
      doneFlag = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule